// File: doc/BRIEF.md
# Video Client Line Output Controller

This block feeds one video processing client from a line buffer. It owns a small control/status word with two software fields: a line-mode field and a frame-start event select. While the selected event has not arrived, the block holds the line buffer back and sends nothing to the client. Once the event is seen, it accepts a fixed number of source lines per frame and forwards them to the client as a pixel stream with end-of-line markers.

In repeat mode, every source line is copied into an internal line store while it is being forwarded. It is then replayed to the client a second time. During the replay the line buffer is held back. Pass-through mode forwards each line once, unchanged. Both fields are taken into account at the start of a frame. The status bit reports whether a frame is in progress.

Top module: `line_out_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0001: idle bit 0 set and both fields zero. `lb_ready_o` and `px_valid_o` are low.
- R2: A write updates only the bits selected by `reg_wmask_i`. The line-mode field is bits 9:8 and the event select is bits 13:10. Writing one field leaves the other field unchanged.
- R3: Bits 31:14 and 7:1 always read as zero. Writes to them have no effect.
- R4: While idle, `lb_ready_o` stays low and no pixel is output. Strobes on events other than the selected one do not start a frame.
- R5: A high pulse on the selected event input while enabled starts a frame. On the next cycle bit 0 reads 0 and `lb_ready_o` is high.
- R6: With line mode 0, each accepted pixel appears on `px_data_o` exactly once, in order, one cycle after acceptance, with its end-of-line flag preserved.
- R7: With line mode 1, each line is output twice in a row, lines of length 1 and `MAX_W` included. `lb_ready_o` is low from the cycle after a line's last pixel is accepted until its replay ends.
- R8: After `FRAME_LINES` source lines the block returns to idle. Bit 0 reads 1 and `lb_ready_o` goes low.
- R9: Line modes 2 and 3 behave exactly like mode 0.
- R10: Event select codes 8 to 15 never start a frame, whatever the event inputs do.
- R11: Code 7 selects the channel-active input `fs_evt_i[7]`, which starts a frame as a level. Codes 0 to 6 select the strobes `fs_evt_i[6:0]` with the same index.
- R12: While `enable_i` is low, no frame starts.
- R13: The line mode is captured when a frame starts. Changing it mid-frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows frames to start |
| fs_evt_i | input | 8 | Frame-start event inputs, indexed by select code |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_wmask_i | input | 32 | Per-bit write enable |
| reg_rdata_o | output | 32 | Control word read value with idle status |
| lb_valid_i | input | 1 | Line buffer pixel valid |
| lb_data_i | input | PIX_W | Line buffer pixel |
| lb_eol_i | input | 1 | Last pixel of a line |
| lb_ready_o | output | 1 | Pixel accepted when high with valid |
| px_valid_o | output | 1 | Client pixel valid |
| px_data_o | output | PIX_W | Client pixel |
| px_eol_o | output | 1 | Client end of line |

## Verification
If the frame state is wrong, the fault shows in the first cycle after a strobe: `lb_ready_o` and bit 0 disagree with the event just driven. If the line counter is wrong, the frame ends a line early or late, and `lb_ready_o` is still high, or already low, when the fourth line's end marker is accepted. A damaged store pointer or replay length shows within one line time as a corrupted or shortened second copy in the client stream. A field merge that is not masked shows on the next read of the control word.

// File: rtl/lco_pkg.sv
`timescale 1ns/1ps
package lco_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_RUN, ST_REPLAY} lco_state_e;
  localparam int LMODE_LSB = 8;
  localparam int FSSEL_LSB = 10;
  localparam int IDLE_BIT  = 0;
  localparam logic [1:0] LMODE_REPEAT = 2'd1;
endpackage

// File: rtl/lco_regs.sv
`timescale 1ns/1ps
module lco_regs
  import lco_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] wmask_i,
  output logic [1:0]  lmode_o,
  output logic [3:0]  fs_sel_o
);
  logic [1:0] lmode_q;
  logic [3:0] fs_q;
  logic [1:0] lm_m;
  logic [3:0] fs_m;

  assign lm_m = wmask_i[LMODE_LSB +: 2];
  assign fs_m = wmask_i[FSSEL_LSB +: 4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lmode_q <= '0;
      fs_q    <= '0;
    end else if (wr_i) begin
      lmode_q <= (lmode_q & ~lm_m) | (wdata_i[LMODE_LSB +: 2] & lm_m);
      fs_q    <= (fs_q & ~fs_m) | (wdata_i[FSSEL_LSB +: 4] & fs_m);
    end
  end

  assign lmode_o  = lmode_q;
  assign fs_sel_o = fs_q;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:14], wdata_i[7:0], wmask_i[31:14], wmask_i[7:0]};
endmodule

// File: rtl/lco_evt_sel.sv
`timescale 1ns/1ps
module lco_evt_sel #(
  parameter int N_EVT = 8
) (
  input  logic [N_EVT-1:0] evt_i,
  input  logic [3:0]       sel_i,
  output logic             hit_o
);
  // codes without a matching input never hit
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < N_EVT; i++) begin
      if (32'(sel_i) == i) hit_o = evt_i[i];
    end
  end
endmodule

// File: rtl/lco_line_store.sv
`timescale 1ns/1ps
module lco_line_store #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [PIX_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [PIX_W-1:0] rdata_o
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/line_out_ctrl.sv
`timescale 1ns/1ps
module line_out_ctrl
  import lco_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int MAX_W       = 16,
  parameter int FRAME_LINES = 4,
  parameter int N_EVT       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [N_EVT-1:0] fs_evt_i,
  input  logic             reg_wr_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic [31:0]      reg_wmask_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             lb_valid_i,
  input  logic [PIX_W-1:0] lb_data_i,
  input  logic             lb_eol_i,
  output logic             lb_ready_o,
  output logic             px_valid_o,
  output logic [PIX_W-1:0] px_data_o,
  output logic             px_eol_o
);
  localparam int AW = (MAX_W > 1) ? $clog2(MAX_W) : 1;
  localparam int CW = $clog2(FRAME_LINES + 1);
  localparam logic [AW-1:0] PTR_MAX  = AW'(MAX_W - 1);
  localparam logic [CW-1:0] LAST_LINE = CW'(FRAME_LINES - 1);

  lco_state_e       st_q;
  logic [1:0]       lmode;
  logic [3:0]       fs_sel;
  logic             start_hit;
  logic             rep_q;
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q, last_q;
  logic [CW-1:0]    line_cnt_q;
  logic [PIX_W-1:0] st_rdata;
  logic             accept;

  lco_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .wmask_i (reg_wmask_i),
    .lmode_o (lmode),
    .fs_sel_o(fs_sel)
  );

  lco_evt_sel #(.N_EVT(N_EVT)) u_evt (
    .evt_i(fs_evt_i),
    .sel_i(fs_sel),
    .hit_o(start_hit)
  );

  assign lb_ready_o = (st_q == ST_RUN);
  assign accept     = lb_ready_o && lb_valid_i;

  lco_line_store #(.PIX_W(PIX_W), .DEPTH(MAX_W)) u_store (
    .clk_i  (clk_i),
    .we_i   (accept && rep_q),
    .waddr_i(wr_ptr_q),
    .wdata_i(lb_data_i),
    .raddr_i(rd_ptr_q),
    .rdata_o(st_rdata)
  );

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[LMODE_LSB +: 2] = lmode;
    reg_rdata_o[FSSEL_LSB +: 4] = fs_sel;
    reg_rdata_o[IDLE_BIT]       = (st_q == ST_WAIT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_WAIT;
      rep_q      <= 1'b0;
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      last_q     <= '0;
      line_cnt_q <= '0;
      px_valid_o <= 1'b0;
      px_data_o  <= '0;
      px_eol_o   <= 1'b0;
    end else begin
      px_valid_o <= 1'b0;
      px_eol_o   <= 1'b0;
      unique case (st_q)
        ST_WAIT: begin
          if (enable_i && start_hit) begin
            st_q       <= ST_RUN;
            rep_q      <= (lmode == LMODE_REPEAT);
            line_cnt_q <= '0;
            wr_ptr_q   <= '0;
          end
        end
        ST_RUN: begin
          if (accept) begin
            px_valid_o <= 1'b1;
            px_data_o  <= lb_data_i;
            px_eol_o   <= lb_eol_i;
            if (!lb_eol_i) begin
              if (wr_ptr_q != PTR_MAX) wr_ptr_q <= wr_ptr_q + 1'b1;
            end else begin
              wr_ptr_q <= '0;
              if (rep_q) begin
                st_q     <= ST_REPLAY;
                rd_ptr_q <= '0;
                last_q   <= wr_ptr_q;
              end else if (line_cnt_q == LAST_LINE) begin
                st_q <= ST_WAIT;
              end else begin
                line_cnt_q <= line_cnt_q + 1'b1;
              end
            end
          end
        end
        ST_REPLAY: begin
          px_valid_o <= 1'b1;
          px_data_o  <= st_rdata;
          px_eol_o   <= (rd_ptr_q == last_q);
          if (rd_ptr_q == last_q) begin
            if (line_cnt_q == LAST_LINE) begin
              st_q <= ST_WAIT;
            end else begin
              st_q       <= ST_RUN;
              line_cnt_q <= line_cnt_q + 1'b1;
            end
          end else begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
          end
        end
        default: st_q <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/lco_checker.sv
`timescale 1ns/1ps
module lco_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        reg_wr_i,
  input logic [31:0] reg_wmask_i,
  input logic [31:0] reg_rdata_o,
  input logic        lb_ready_o,
  input logic        px_valid_o,
  input logic        px_eol_o
);
  // R2: field changes only through its own mask bits
  a_r2_lmode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i || reg_wmask_i[9:8] == 2'b00) |=> $stable(reg_rdata_o[9:8]));
  a_r2_fssel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i || reg_wmask_i[13:10] == 4'b0000) |=> $stable(reg_rdata_o[13:10]));
  // R3
  a_r3_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31:14] == '0 && reg_rdata_o[7:1] == '0);
  // R4
  a_r4_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && $past(reg_rdata_o[0])) |-> !px_valid_o);
  a_r4_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_ready_o |-> !reg_rdata_o[0]);
  // R6
  a_r6_eol_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_eol_o |-> px_valid_o);
  // R10
  a_r10_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && reg_rdata_o[13]) |=> reg_rdata_o[0]);
  // R12
  a_r12_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && !enable_i) |=> reg_rdata_o[0]);
endmodule

bind line_out_ctrl lco_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wmask_i(reg_wmask_i),
  .reg_rdata_o(reg_rdata_o),
  .lb_ready_o (lb_ready_o),
  .px_valid_o (px_valid_o),
  .px_eol_o   (px_eol_o)
);

// File: tb/sim_line_out_ctrl.sv
`timescale 1ns/1ps
module sim_line_out_ctrl;
  localparam int PIX_W = 8;
  localparam int MAX_W = 8;
  localparam int FL    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [7:0] fs_evt = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_wmask = '0, reg_rdata;
  logic lb_valid = 1'b0, lb_eol = 1'b0, lb_ready;
  logic [PIX_W-1:0] lb_data = '0;
  logic px_valid, px_eol;
  logic [PIX_W-1:0] px_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [PIX_W:0] got[$];
  logic [PIX_W:0] exp[$];

  always #4 clk = ~clk;

  line_out_ctrl #(.PIX_W(PIX_W), .MAX_W(MAX_W), .FRAME_LINES(FL), .N_EVT(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .fs_evt_i(fs_evt),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_wmask_i(reg_wmask),
    .reg_rdata_o(reg_rdata), .lb_valid_i(lb_valid), .lb_data_i(lb_data),
    .lb_eol_i(lb_eol), .lb_ready_o(lb_ready), .px_valid_o(px_valid),
    .px_data_o(px_data), .px_eol_o(px_eol)
  );

  always @(negedge clk) if (rst_n && px_valid) got.push_back({px_eol, px_data});

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    fs_evt[idx] = 1'b1;
    @(negedge clk);
    fs_evt[idx] = 1'b0;
  endtask

  task automatic send_line(input int len, input int base, input bit rep);
    for (int i = 0; i < len; i++) begin
      lb_valid = 1'b1; lb_data = PIX_W'(base + i); lb_eol = (i == len - 1);
      while (!lb_ready) @(negedge clk);
      @(negedge clk);
    end
    lb_valid = 1'b0; lb_eol = 1'b0;
    for (int r = 0; r < (rep ? 2 : 1); r++)
      for (int i = 0; i < len; i++) exp.push_back({(i == len - 1), PIX_W'(base + i)});
  endtask

  task automatic check_stream(input string req);
    int bad;
    repeat (MAX_W + 4) @(negedge clk);
    bad = -1;
    if (got.size() == exp.size()) begin
      for (int i = 0; i < got.size(); i++) if (bad < 0 && got[i] !== exp[i]) bad = i;
      if (bad < 0) chk(1'b1, req, 0, 0);
      else chk(1'b0, req, 32'(got[bad]), 32'(exp[bad]));
    end else chk(1'b0, {req, " length"}, got.size(), exp.size());
    got.delete(); exp.delete();
  endtask

  task automatic check_idle(input string req);
    chk(reg_rdata[0] == 1'b1, {req, " idle"}, reg_rdata[0], 1);
    chk(lb_ready == 1'b0, {req, " ready"}, lb_ready, 0);
  endtask

  task automatic t_reset();
    chk(reg_rdata == 32'h1, "R1 control word", reg_rdata, 32'h1);
    chk(!lb_ready, "R1 ready", lb_ready, 0);
    chk(!px_valid, "R1 valid", px_valid, 0);
  endtask

  task automatic t_regs();
    wr(32'h0000_0100, 32'h0000_0300);
    wr(32'h0000_0C00, 32'h0000_3C00);
    @(negedge clk);
    chk(reg_rdata == 32'h0D01, "R2 merge", reg_rdata, 32'h0D01);
    wr(32'hFFFF_FFFF, 32'hFFFF_C0FF);
    @(negedge clk);
    chk(reg_rdata == 32'h0D01, "R3 masked bits", reg_rdata, 32'h0D01);
    wr(32'h0000_0000, 32'h0000_0300);
    @(negedge clk);
    chk(reg_rdata == 32'h0C01, "R2 keep select", reg_rdata, 32'h0C01);
  endtask

  task automatic t_gate();
    enable = 1'b0;
    pulse(3);
    @(negedge clk);
    check_idle("R12");
    enable = 1'b1;
    pulse(2); pulse(1); pulse(7);
    repeat (2) @(negedge clk);
    check_idle("R4");
    chk(got.size() == 0, "R4 no output", got.size(), 0);
    @(negedge clk); fs_evt[3] = 1'b1;
    @(negedge clk); fs_evt[3] = 1'b0;
    chk(reg_rdata[0] == 1'b0 && lb_ready, "R5 start", {reg_rdata[0], lb_ready}, 32'h1);
  endtask

  task automatic t_pass();
    send_line(3, 8'h10, 0);
    send_line(1, 8'h20, 0);
    send_line(MAX_W, 8'h30, 0);
    send_line(2, 8'h40, 0);
    check_idle("R8 pass");
    check_stream("R6 pass-through stream");
  endtask

  task automatic t_mirror();
    wr(32'h0000_1D00, 32'h0000_3F00);
    @(negedge clk); fs_evt[7] = 1'b1;
    @(negedge clk); fs_evt[7] = 1'b0;
    chk(reg_rdata[0] == 1'b0, "R11 channel active start", reg_rdata[0], 0);
    send_line(2, 8'h50, 1);
    chk(!lb_ready, "R7 hold during replay", lb_ready, 0);
    send_line(1, 8'h60, 1);
    send_line(MAX_W, 8'h70, 1);
    send_line(3, 8'h80, 1);
    repeat (MAX_W + 2) @(negedge clk);
    check_idle("R8 repeat");
    check_stream("R7 repeat stream");
  endtask

  task automatic t_reserved();
    for (int m = 2; m < 4; m++) begin
      wr(32'(m) << 8, 32'h0000_3F00);
      pulse(0);
      for (int l = 0; l < FL; l++) send_line(2 + l, 16 * l + m, 0);
      check_stream("R9 reserved mode");
    end
  endtask

  task automatic t_badcode();
    for (int c = 8; c < 16; c++) begin
      wr(32'(c) << 10, 32'h0000_3C00);
      @(negedge clk); fs_evt = 8'hFF;
      repeat (2) @(negedge clk); fs_evt = 8'h00;
      @(negedge clk);
      chk(reg_rdata[0] && !lb_ready, "R10 code ignored", c, 1);
    end
  endtask

  task automatic t_latch();
    wr(32'h0000_0400, 32'h0000_3F00);
    pulse(1);
    send_line(2, 8'h90, 0);
    wr(32'h0000_0100, 32'h0000_0300);
    send_line(3, 8'hA0, 0);
    send_line(1, 8'hB0, 0);
    send_line(2, 8'hC0, 0);
    check_stream("R13 mode kept in frame");
    pulse(1);
    for (int l = 0; l < FL; l++) send_line(2, 8'hD0 + 4 * l, 1);
    check_stream("R13 mode applied next frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gate();
    t_pass();
    t_mirror();
    t_reserved();
    t_badcode();
    t_latch();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule